// File: doc/BRIEF.md
# Interleaved Block-Fill Scheduler

This block fills a cache block from a group of independent memory banks whose words are interleaved at word granularity. Word `w` of the address space lives in bank `w mod NB` at in-bank location `w / NB`. All words of one block therefore sit at the same in-bank location, one per bank. One block address on the request side starts one access in every bank during a single address cycle. The accesses overlap, so after one access time the words stream out one per cycle instead of paying the whole access cost for each word.

The requester offers a block address with a valid/ready handshake. The scheduler drives a shared in-bank address and one request line per bank. Each bank answers after its access time with a return strobe and a data word. The words are held in per-bank slots and presented in ascending word order on an output stream with valid and last flags. A per-bank busy counter keeps a bank from being requested again before its access time has run out. A new block is taken only after the previous one has been fully presented.

With the default parameters (four banks, six-cycle bank access, one address cycle, one cycle per word), a block completes in 1 + 6 + 4 = 11 cycles. A non-interleaved memory would need 4 x (1 + 6 + 1) = 32 cycles for the same block.

Top module: `ilv_fill_sched`

## Requirements
- R1: After reset, `req_ready_o` is high, `out_valid_o` and `out_last_o` are low and no `bank_req_o` bit is set.
- R2: A request is taken in a cycle in which `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from the next cycle up to and including the cycle that presents the final word of that block.
- R3: In the cycle after acceptance, every bit of `bank_req_o` is high and `bank_addr_o` carries the block address. The word address is block*NB + bank index. The bank index is the low log2(NB) bits of the word address, and the in-bank address is the remaining upper bits.
- R4: Each bank receives exactly one request cycle per block, and no bank is requested outside a block.
- R5: Words are presented in ascending order. `out_waddr_o` is block*NB + k and `out_data_o` is the word that bank k returned for that block.
- R6: When all banks take the same access time L (default 6) and acceptance happens in cycle c, word k is presented in cycle c+L+2+k. The last word therefore falls 11 cycles after the start of the address cycle.
- R7: Once the first word is out and every bank has returned, the remaining words follow on consecutive cycles with no gap.
- R8: `out_last_o` is high together with the final word of a block (word index NB-1) and low in every other cycle.
- R9: A bank is never requested again within BANK_LAT cycles of its previous request.
- R10: `req_valid_i` asserted while `req_ready_o` is low is ignored. It starts no bank request and does not change the block being presented.
- R11: A return strobe from a bank that has no access outstanding is ignored, and its data never appears on the output.
- R12: When banks return at different times, word k is presented in the cycle after the later of two events: the presentation of word k-1, and the return from bank k. Order stays ascending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Block-fill request valid |
| req_blk_i | input | AW | Block address of the request |
| req_ready_o | output | 1 | Scheduler can take a request |
| bank_req_o | output | NB | Per-bank access request, one bit per bank |
| bank_addr_o | output | AW | Shared in-bank address |
| bank_rvalid_i | input | NB | Per-bank return strobe |
| bank_rdata_i | input | NB*DW | Per-bank return data, bank k at bits k*DW +: DW |
| out_valid_o | output | 1 | Output word valid |
| out_last_o | output | 1 | Output word is the last of the block |
| out_waddr_o | output | AW+log2(NB) | Word address of the output word |
| out_data_o | output | DW | Output word data |

## Verification
Each result has a due cycle measured from the handshake cycle c. The bank requests are due in cycle c+1. Word k is due in the cycle after the later of two events: its bank's return, which is c+1 plus that bank's latency, and the previous word. Ready is due back one cycle after the last word. The bench reference computes these due cycles from the handshake and the latency it gives each bank model. It then compares every output at each falling edge, so a word one cycle early or late fails. Skewed latencies, stray return strobes and requests held during a busy block check that the due cycles and data stay as predicted.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned NB_DEF  = 4;
    localparam int unsigned DW_DEF  = 32;
    localparam int unsigned AW_DEF  = 10;
    localparam int unsigned LAT_DEF = 6;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } sched_st_e;

    function automatic int unsigned idx_bits(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
    parameter int unsigned LAT = ilv_pkg::LAT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(LAT + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire_i) begin
            cnt_q <= CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle_o = (cnt_q == '0);

    // checker-only spacing counter, independent of cnt_q
    logic [CW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fire_i) begin
            gap_q  <= CW'(1);
            seen_q <= 1'b1;
        end else if (gap_q <= CW'(LAT)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R9
    bank_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_i && seen_q) |-> (gap_q > CW'(LAT)));

endmodule

// File: rtl/ilv_word_slot.sv
module ilv_word_slot #(
    parameter int unsigned DW = ilv_pkg::DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_i,
    input  logic          clear_i,
    input  logic          rvalid_i,
    input  logic [DW-1:0] rdata_i,
    output logic          avail_o,
    output logic [DW-1:0] word_o
);
    logic          pending_q;
    logic          filled_q;
    logic [DW-1:0] buf_q;
    logic          take;

    assign take = pending_q && rvalid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            filled_q  <= 1'b0;
            buf_q     <= '0;
        end else if (clear_i) begin
            pending_q <= 1'b0;
            filled_q  <= 1'b0;
        end else if (issue_i) begin
            pending_q <= 1'b1;
        end else if (take) begin
            pending_q <= 1'b0;
            filled_q  <= 1'b1;
            buf_q     <= rdata_i;
        end
    end

    assign avail_o = filled_q || take;
    assign word_o  = filled_q ? buf_q : rdata_i;

    // R11
    stray_return_chk: assert property (@(posedge clk) disable iff (rst)
        (rvalid_i && !pending_q) |=> $stable(buf_q));

endmodule

// File: rtl/ilv_fill_sched.sv
module ilv_fill_sched #(
    parameter int unsigned NB       = ilv_pkg::NB_DEF,
    parameter int unsigned DW       = ilv_pkg::DW_DEF,
    parameter int unsigned AW       = ilv_pkg::AW_DEF,
    parameter int unsigned BANK_LAT = ilv_pkg::LAT_DEF,
    localparam int unsigned IW      = ilv_pkg::idx_bits(NB),
    localparam int unsigned WA      = AW + IW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    input  logic [AW-1:0]    req_blk_i,
    output logic             req_ready_o,
    output logic [NB-1:0]    bank_req_o,
    output logic [AW-1:0]    bank_addr_o,
    input  logic [NB-1:0]    bank_rvalid_i,
    input  logic [NB*DW-1:0] bank_rdata_i,
    output logic             out_valid_o,
    output logic             out_last_o,
    output logic [WA-1:0]    out_waddr_o,
    output logic [DW-1:0]    out_data_o
);
    ilv_pkg::sched_st_e state_q;
    logic [AW-1:0]      blk_q;
    logic [NB-1:0]      issued_q;
    logic [IW-1:0]      ptr_q;

    logic [NB-1:0]      idle_w;
    logic [NB-1:0]      avail_w;
    logic [DW-1:0]      word_w [NB];

    logic               accept;
    logic               ptr_is_last;
    logic               deliver;
    logic               deliver_last;

    assign accept       = req_valid_i && req_ready_o;
    assign ptr_is_last  = (ptr_q == IW'(NB - 1));
    assign deliver      = (state_q == ilv_pkg::S_BUSY) && avail_w[ptr_q];
    assign deliver_last = deliver && ptr_is_last;

    assign bank_req_o  = (state_q == ilv_pkg::S_BUSY) ? (~issued_q & idle_w) : '0;
    assign bank_addr_o = blk_q;
    assign req_ready_o = (state_q == ilv_pkg::S_IDLE) && !out_valid_o;

    for (genvar k = 0; k < NB; k++) begin : g_bank
        ilv_bank_timer #(.LAT(BANK_LAT)) u_timer (
            .clk    (clk),
            .rst    (rst),
            .fire_i (bank_req_o[k]),
            .idle_o (idle_w[k])
        );

        ilv_word_slot #(.DW(DW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .issue_i  (bank_req_o[k]),
            .clear_i  (deliver_last),
            .rvalid_i (bank_rvalid_i[k]),
            .rdata_i  (bank_rdata_i[k*DW +: DW]),
            .avail_o  (avail_w[k]),
            .word_o   (word_w[k])
        );

        // R4
        one_req_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
            bank_req_o[k] |=> !bank_req_o[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ilv_pkg::S_IDLE;
            blk_q       <= '0;
            issued_q    <= '0;
            ptr_q       <= '0;
            out_valid_o <= 1'b0;
            out_last_o  <= 1'b0;
            out_waddr_o <= '0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= deliver;
            out_last_o  <= deliver_last;
            if (deliver) begin
                out_data_o  <= word_w[ptr_q];
                out_waddr_o <= {blk_q, ptr_q};
                ptr_q       <= ptr_is_last ? '0 : ptr_q + 1'b1;
            end
            case (state_q)
                ilv_pkg::S_IDLE: begin
                    if (accept) begin
                        state_q  <= ilv_pkg::S_BUSY;
                        blk_q    <= req_blk_i;
                        issued_q <= '0;
                        ptr_q    <= '0;
                    end
                end
                default: begin
                    issued_q <= issued_q | bank_req_o;
                    if (deliver_last) begin
                        state_q <= ilv_pkg::S_IDLE;
                    end
                end
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !out_last_o && (bank_req_o == '0) && req_ready_o));

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready_o);

    // R5
    ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_last_o) |=>
            (!out_valid_o || (out_waddr_o == WA'($past(out_waddr_o) + 1'b1))));

    // R8
    last_ends_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_last_o) |=> !out_valid_o);

    // R10
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_ready_o) |=> $stable(bank_addr_o));

endmodule

// File: tb/tb_ilv_fill_sched.sv
`timescale 1ns/1ps
module tb_ilv_fill_sched;
    localparam int NB  = 4;
    localparam int DW  = 32;
    localparam int AW  = 10;
    localparam int LAT = 6;
    localparam int IW  = 2;
    localparam int WA  = AW + IW;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic [AW-1:0]    req_blk;
    logic             req_ready;
    logic [NB-1:0]    bank_req;
    logic [AW-1:0]    bank_addr;
    logic [NB-1:0]    bank_rvalid;
    logic [NB*DW-1:0] bank_rdata;
    logic             out_valid;
    logic             out_last;
    logic [WA-1:0]    out_waddr;
    logic [DW-1:0]    out_data;

    always #2.5 clk = ~clk;

    ilv_fill_sched #(.NB(NB), .DW(DW), .AW(AW), .BANK_LAT(LAT)) dut (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_blk_i(req_blk), .req_ready_o(req_ready),
        .bank_req_o(bank_req), .bank_addr_o(bank_addr),
        .bank_rvalid_i(bank_rvalid), .bank_rdata_i(bank_rdata),
        .out_valid_o(out_valid), .out_last_o(out_last),
        .out_waddr_o(out_waddr), .out_data_o(out_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "base";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] fdat(int k, logic [AW-1:0] a);
        return 32'h5A00_0000 | (32'(a) << 8) | 32'(k);
    endfunction

    // behavioural bank model: fixed latency plus per-bank extra delay
    int            bcnt  [NB];
    logic [AW-1:0] baddr [NB];
    int            extra [NB];
    logic          spur  [NB];

    always @(posedge clk) begin
        for (int k = 0; k < NB; k++) begin
            if (rst) begin
                bcnt[k] <= 0;
            end else if (bank_req[k]) begin
                bcnt[k]  <= LAT + extra[k];
                baddr[k] <= bank_addr;
            end else if (bcnt[k] > 0) begin
                bcnt[k] <= bcnt[k] - 1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            bank_rvalid[k] = (bcnt[k] == 1) || spur[k];
            bank_rdata[k*DW +: DW] = (bcnt[k] == 1) ? fdat(k, baddr[k]) : (32'hDEAD_0000 | 32'(k));
        end
    end

    // reference model state
    int            acc = -100;
    int            dexp [NB];
    logic [AW-1:0] eblk;
    bit            active = 0;
    bit            mon_en = 0;
    int            obs_first = -1;
    int            obs_last  = -1;
    int            blkreq [NB];
    int            lastreq [NB];
    bit            everreq [NB];

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s] cyc=%0d actual=%0h expected=%0h", rq, what, tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            bit in_block;
            bit ev;
            int ek;
            logic [NB-1:0] ebreq;
            in_block = active && (cyc > acc) && (cyc <= dexp[NB-1]);
            chk(req_ready == !in_block, "R2", "req_ready", req_ready, !in_block);
            ebreq = (active && cyc == acc + 1) ? '1 : '0;
            chk(bank_req == ebreq, "R3", "bank_req", bank_req, ebreq);
            if (bank_req != '0) chk(bank_addr == eblk, "R3", "bank_addr", bank_addr, eblk);
            for (int k = 0; k < NB; k++) begin
                if (bank_req[k]) begin
                    if (everreq[k]) chk((cyc - lastreq[k]) > LAT, "R9", "bank spacing", cyc - lastreq[k], LAT + 1);
                    everreq[k] = 1;
                    lastreq[k] = cyc;
                    blkreq[k]++;
                end
            end
            ev = 0;
            ek = 0;
            for (int k = 0; k < NB; k++) begin
                if (active && dexp[k] == cyc) begin
                    ev = 1;
                    ek = k;
                end
            end
            chk(out_valid == ev, "R6", "out_valid", out_valid, ev);
            if (ev) begin
                chk(out_waddr == {eblk, IW'(ek)}, "R5", "out_waddr", out_waddr, {eblk, IW'(ek)});
                chk(out_data == fdat(ek, eblk), "R5", "out_data", out_data, fdat(ek, eblk));
                chk(out_last == (ek == NB - 1), "R8", "out_last", out_last, (ek == NB - 1));
            end else begin
                chk(out_last == 1'b0, "R8", "out_last idle", out_last, 0);
            end
            if (out_valid) begin
                if (obs_first < 0) obs_first = cyc;
                obs_last = cyc;
            end
        end
    end

    task automatic start_block(logic [AW-1:0] b);
        int r;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_blk   = b;
        acc       = cyc;
        eblk      = b;
        obs_first = -1;
        obs_last  = -1;
        for (int k = 0; k < NB; k++) begin
            blkreq[k] = 0;
            r = acc + 1 + LAT + extra[k];
            if (k == 0) dexp[k] = r + 1;
            else        dexp[k] = ((dexp[k-1] + 1) > (r + 1)) ? (dexp[k-1] + 1) : (r + 1);
        end
        active = 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_block();
        while (cyc <= dexp[NB-1] + 1) @(negedge clk);
        for (int k = 0; k < NB; k++)
            chk(blkreq[k] == 1, "R4", "requests per bank", blkreq[k], 1);
    endtask

    task automatic set_extra(int e0, int e1, int e2, int e3);
        extra[0] = e0; extra[1] = e1; extra[2] = e2; extra[3] = e3;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired cyc=%0d actual=hung expected=done", cyc);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_blk = '0;
        for (int k = 0; k < NB; k++) begin
            extra[k] = 0; spur[k] = 1'b0; blkreq[k] = 0; lastreq[k] = 0; everreq[k] = 0; dexp[k] = -100;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);
        chk(bank_req == '0, "R1", "bank_req after reset", bank_req, 0);
        rst = 1'b0;
        mon_en = 1;
        repeat (2) @(negedge clk);

        // R6 R7: single block with equal latency
        tag = "R6";
        start_block(10'd5);
        finish_block();
        chk(obs_first == acc + LAT + 2, "R6", "first word cycle", obs_first - acc, LAT + 2);
        chk(obs_last == acc + LAT + 5, "R6", "last word cycle", obs_last - acc, LAT + 5);
        chk(obs_last - obs_first == NB - 1, "R7", "burst length", obs_last - obs_first, NB - 1);

        // R9 back-to-back blocks, address boundaries
        tag = "R9";
        start_block(10'd0);
        finish_block();
        start_block(10'h3FF);
        finish_block();
        chk(obs_last - obs_first == NB - 1, "R7", "burst length b2b", obs_last - obs_first, NB - 1);
        start_block(10'h200);
        finish_block();

        // R10 requests while busy
        tag = "R10";
        start_block(10'd7);
        req_valid = 1'b1;
        req_blk = 10'd9;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        finish_block();
        chk(obs_first == acc + LAT + 2, "R10", "block kept timing", obs_first - acc, LAT + 2);

        // R12 skewed bank latencies
        tag = "R12";
        set_extra(3, 0, 5, 1);
        start_block(10'd100);
        finish_block();
        chk(obs_first == acc + LAT + 5, "R12", "first word skew", obs_first - acc, LAT + 5);
        chk(obs_last == acc + LAT + 8, "R12", "last word skew", obs_last - acc, LAT + 8);
        set_extra(0, 4, 0, 0);
        start_block(10'd101);
        finish_block();
        chk(obs_last == acc + LAT + 8, "R12", "gap before word1", obs_last - acc, LAT + 8);
        set_extra(0, 0, 0, 0);

        // R11 stray return strobes
        tag = "R11";
        @(negedge clk);
        spur[2] = 1'b1;
        @(negedge clk);
        spur[2] = 1'b0;
        obs_first = -1;
        repeat (3) @(negedge clk);
        chk(obs_first == -1, "R11", "no output from idle strobe", obs_first, -1);
        set_extra(4, 0, 0, 0);
        start_block(10'd33);
        while (cyc != acc + 9) @(negedge clk);
        spur[1] = 1'b1;
        @(negedge clk);
        spur[1] = 1'b0;
        finish_block();
        set_extra(0, 0, 0, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule